// File: doc/BRIEF.md
# Rank-Ordered Best-Four Track Selector

This block picks the four strongest track candidates out of thirty-six offered on each bunch crossing. The candidates arrive as twelve source ports carrying three words each. Every word holds a 7-bit rank and a small payload. The block ranks all thirty-six against each other and fills four output slots in descending order of rank. Each forwarded rank then goes through a quality lookup table before it leaves the block. In the same output cycle, the block returns one flag per candidate, so each source port learns which of its words were forwarded.

The pipeline has a fixed depth of three clock cycles, which is well inside a five-cycle budget at a 40 MHz crossing rate. Two 64-entry capture buffers record what the selector saw and what it produced, so a test can read both back one word at a time and compare them offline. Each buffer stops recording when it is full, and it stays frozen until a clear pulse.

Top module: `trk_rank_sel`

## Requirements
- R1: Candidate `i` lies at bits `[i*11 +: 11]` of `cand_i`, with `i = port*3 + position`. The rank occupies the low 7 bits of the word and the 4-bit payload the upper 4. `out_src` reports `i` for each slot.
- R2: The selector forwards the four highest-ranked non-empty candidates. Slot 0 holds the highest rank and the slots follow in non-increasing rank order.
- R3: When two candidates have equal rank, the one with the lower index `i` is placed first.
- R4: A rank of zero marks an empty candidate, which is never forwarded or flagged. When fewer than four candidates are non-empty, the surplus slots show `out_vld` = 0 with every field at zero.
- R5: `out_q` for a slot equals ceil(rank*7/127) of the forwarded rank, so rank 0 gives 0, ranks 1 to 18 give 1, and rank 127 gives 7. `out_pay` is the payload of that candidate, unchanged.
- R6: A crossing presented with `in_vld` high at clock edge n appears at edge n+3 with `out_xvld` high. A crossing with `in_vld` low produces `out_xvld` = 0 and all-zero outputs three edges later.
- R7: `win_o[i]` is 1 exactly when candidate `i` was forwarded, and it is aligned to the same crossing as the output slots.
- R8: Each valid crossing adds one entry to each capture buffer: the 36 input words, and the four output lanes `{out_pay, zero-extended out_q}`. A crossing with `in_vld` low adds nothing. After 64 entries a buffer freezes and raises its `tcap_full` bit, with bit 0 for the input buffer and bit 1 for the output buffer.
- R9: `tcap_rdata` shows lane `tcap_lane` of the entry at the read pointer of the buffer chosen by `tcap_sel` (0 for input, 1 for output). A lane past the buffer's width reads as zero. `tcap_adv` steps the read pointer, which wraps after 64. `tcap_clr` sets both pointers of both buffers to zero and clears `tcap_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Crossing valid |
| cand_i | input | 396 | Thirty-six candidate words |
| out_xvld | output | 1 | Output crossing valid |
| out_vld | output | 4 | Slot occupied flags |
| out_q | output | 12 | Per-slot remapped quality |
| out_pay | output | 16 | Per-slot payload |
| out_src | output | 24 | Per-slot candidate index |
| win_o | output | 36 | Per-candidate forwarded flags |
| tcap_clr | input | 1 | Clear both capture buffers |
| tcap_adv | input | 1 | Advance read pointer |
| tcap_sel | input | 1 | Buffer select, 0 input and 1 output |
| tcap_lane | input | 6 | Lane within the entry |
| tcap_rdata | output | 11 | Read word |
| tcap_full | output | 2 | Buffer frozen flags |

## Verification
A faulty rank count shows up three cycles after the crossing that triggers it. It appears as a slot holding the wrong index or a misordered quality, a winner flag that disagrees with the slot contents, or two slots claiming one candidate. A broken tie-break shows only when ranks collide, so the stimulus runs all-equal crossings and random crossings drawn from a narrow rank band. Capture faults stay hidden until readback, so the buffers are filled past 64 entries and then read back at the first entry, the last entry and the wrap point.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

  typedef enum logic {
    CAP_IN  = 1'b0,
    CAP_OUT = 1'b1
  } cap_sel_e;

  // Quality code: ceiling of rank scaled from the rank range onto the code range.
  function automatic int unsigned q_of_rank(int unsigned r, int unsigned rw, int unsigned qw);
    int unsigned rmax;
    int unsigned qmax;
    rmax = (32'd1 << rw) - 32'd1;
    qmax = (32'd1 << qw) - 32'd1;
    return (r * qmax + rmax - 32'd1) / rmax;
  endfunction

endpackage

// File: rtl/bsel_tally.sv
module bsel_tally #(
  parameter int N_CAND = 36,
  parameter int RANK_W = 7,
  parameter int N_OUT  = 4,
  localparam int CNT_W  = $clog2(N_CAND + 1),
  localparam int SLOT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CAND*RANK_W-1:0] rank_i,
  output logic [N_CAND-1:0]        win_q,
  output logic [N_CAND*SLOT_W-1:0] slot_q
);

  logic [N_CAND-1:0]        win_n;
  logic [N_CAND*SLOT_W-1:0] slot_n;

  // Each candidate counts how many others outrank it; that count is its slot.
  for (genvar gi = 0; gi < N_CAND; gi++) begin : g_cand
    logic [CNT_W-1:0]  beat;
    logic [RANK_W-1:0] me;
    assign me = rank_i[gi*RANK_W +: RANK_W];

    always_comb begin
      beat = '0;
      for (int j = 0; j < N_CAND; j++) begin
        if (j != gi) begin
          if ((rank_i[j*RANK_W +: RANK_W] > me) ||
              ((rank_i[j*RANK_W +: RANK_W] == me) && (j < gi))) begin
            beat = beat + CNT_W'(1);
          end
        end
      end
    end

    assign win_n[gi] = (me != '0) && (beat < CNT_W'(N_OUT));
    assign slot_n[gi*SLOT_W +: SLOT_W] = win_n[gi] ? beat[SLOT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      slot_q <= '0;
    end else begin
      win_q  <= win_n;
      slot_q <= slot_n;
    end
  end

  // R2
  win_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_q) <= N_OUT);

endmodule

// File: rtl/bsel_route.sv
module bsel_route
  import bsel_pkg::*;
#(
  parameter int N_CAND = 36,
  parameter int RANK_W = 7,
  parameter int PAY_W  = 4,
  parameter int N_OUT  = 4,
  parameter int Q_W    = 3,
  localparam int W      = RANK_W + PAY_W,
  localparam int IDX_W  = $clog2(N_CAND),
  localparam int SLOT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int N_RANK = 1 << RANK_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic [N_CAND*W-1:0]      words_i,
  input  logic [N_CAND-1:0]        win_i,
  input  logic [N_CAND*SLOT_W-1:0] slot_i,
  output logic                     xvld_q,
  output logic [N_OUT-1:0]         vld_q,
  output logic [N_OUT*Q_W-1:0]     q_q,
  output logic [N_OUT*PAY_W-1:0]   pay_q,
  output logic [N_OUT*IDX_W-1:0]   src_q,
  output logic [N_CAND-1:0]        win_q
);

  // Quality lookup table, filled with constants at elaboration.
  logic [Q_W-1:0] qtab [N_RANK];
  for (genvar gv = 0; gv < N_RANK; gv++) begin : g_tab
    assign qtab[gv] = Q_W'(q_of_rank(gv, RANK_W, Q_W));
  end

  logic [N_OUT-1:0]       vld_n;
  logic [N_OUT*Q_W-1:0]   q_n;
  logic [N_OUT*PAY_W-1:0] pay_n;
  logic [N_OUT*IDX_W-1:0] src_n;

  for (genvar gk = 0; gk < N_OUT; gk++) begin : g_slot
    logic [N_CAND-1:0] hit;
    logic [W-1:0]      word;
    logic [IDX_W-1:0]  src;

    always_comb begin
      hit  = '0;
      word = '0;
      src  = '0;
      for (int i = 0; i < N_CAND; i++) begin
        if (win_i[i] && (slot_i[i*SLOT_W +: SLOT_W] == SLOT_W'(gk))) begin
          hit[i] = 1'b1;
          word   = word | words_i[i*W +: W];
          src    = src | IDX_W'(i);
        end
      end
    end

    assign vld_n[gk]                  = |hit;
    assign q_n[gk*Q_W +: Q_W]         = qtab[word[RANK_W-1:0]];
    assign pay_n[gk*PAY_W +: PAY_W]   = word[W-1:RANK_W];
    assign src_n[gk*IDX_W +: IDX_W]   = src;

    // R2
    slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

    // R4
    out_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[gk] |-> (q_q[gk*Q_W +: Q_W] != '0));

    if (gk < N_OUT - 1) begin : g_ord
      // R2
      out_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[gk+1] |-> (vld_q[gk] && (q_q[gk*Q_W +: Q_W] >= q_q[(gk+1)*Q_W +: Q_W])));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xvld_q <= 1'b0;
      vld_q  <= '0;
      q_q    <= '0;
      pay_q  <= '0;
      src_q  <= '0;
      win_q  <= '0;
    end else begin
      xvld_q <= vld_i;
      vld_q  <= vld_n;
      q_q    <= q_n;
      pay_q  <= pay_n;
      src_q  <= src_n;
      win_q  <= win_i;
    end
  end

  // R7
  win_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_q) == $countones(vld_q));

endmodule

// File: rtl/bsel_capbuf.sv
module bsel_capbuf #(
  parameter int DEPTH  = 64,
  parameter int N_LANE = 36,
  parameter int LANE_W = 11,
  parameter int SEL_W  = 6,
  localparam int ENT_W = N_LANE * LANE_W,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [ENT_W-1:0] data_i,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [SEL_W-1:0] lane_i,
  output logic [LANE_W-1:0] rdata_o,
  output logic             full_o
);

  logic [PTR_W:0]   wr_cnt, cnt_n;
  logic [PTR_W-1:0] rd_ptr, rd_n;
  logic             do_wr;
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] ent;

  assign full_o = (wr_cnt == (PTR_W+1)'(DEPTH));
  assign do_wr  = wr_i && !full_o && !clr_i;

  always_comb begin
    cnt_n = wr_cnt;
    rd_n  = rd_ptr;
    if (clr_i) begin
      cnt_n = '0;
      rd_n  = '0;
    end else begin
      if (do_wr) cnt_n = wr_cnt + (PTR_W+1)'(1);
      if (adv_i) rd_n  = rd_ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      rd_ptr <= '0;
    end else begin
      wr_cnt <= cnt_n;
      rd_ptr <= rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_cnt[PTR_W-1:0]] <= data_i;
  end

  assign ent = mem[rd_ptr];

  always_comb begin
    if (int'(lane_i) < N_LANE) rdata_o = ent[int'(lane_i)*LANE_W +: LANE_W];
    else                       rdata_o = '0;
  end

  // R8
  cap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !clr_i) |=> (full_o && $stable(wr_cnt)));

  // R8
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= (PTR_W+1)'(DEPTH));

endmodule

// File: rtl/trk_rank_sel.sv
module trk_rank_sel
  import bsel_pkg::*;
#(
  parameter int N_PORT    = 12,
  parameter int PER_PORT  = 3,
  parameter int RANK_W    = 7,
  parameter int PAY_W     = 4,
  parameter int N_OUT     = 4,
  parameter int Q_W       = 3,
  parameter int CAP_DEPTH = 64,
  localparam int N_CAND = N_PORT * PER_PORT,
  localparam int W      = RANK_W + PAY_W,
  localparam int IDX_W  = $clog2(N_CAND),
  localparam int SLOT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int LSEL_W = $clog2(N_CAND)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic [N_CAND*W-1:0]    cand_i,
  output logic                   out_xvld,
  output logic [N_OUT-1:0]       out_vld,
  output logic [N_OUT*Q_W-1:0]   out_q,
  output logic [N_OUT*PAY_W-1:0] out_pay,
  output logic [N_OUT*IDX_W-1:0] out_src,
  output logic [N_CAND-1:0]      win_o,
  input  logic                   tcap_clr,
  input  logic                   tcap_adv,
  input  logic                   tcap_sel,
  input  logic [LSEL_W-1:0]      tcap_lane,
  output logic [W-1:0]           tcap_rdata,
  output logic [1:0]             tcap_full
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q_n = rsync[1];

  // Stage 0: capture the crossing; an invalid crossing enters as all-empty.
  logic [N_CAND*W-1:0] s0_words, s0_words_n;
  logic                s0_vld;
  assign s0_words_n = in_vld ? cand_i : '0;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s0_words <= '0;
      s0_vld   <= 1'b0;
    end else begin
      s0_words <= s0_words_n;
      s0_vld   <= in_vld;
    end
  end

  logic [N_CAND*RANK_W-1:0] s0_rank;
  for (genvar gi = 0; gi < N_CAND; gi++) begin : g_rank
    assign s0_rank[gi*RANK_W +: RANK_W] = s0_words[gi*W +: RANK_W];
  end

  // Stage 1: rank tally, words carried alongside.
  logic [N_CAND-1:0]        s1_win;
  logic [N_CAND*SLOT_W-1:0] s1_slot;
  logic [N_CAND*W-1:0]      s1_words;
  logic                     s1_vld;

  bsel_tally #(.N_CAND(N_CAND), .RANK_W(RANK_W), .N_OUT(N_OUT)) u_tally (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .rank_i (s0_rank),
    .win_q  (s1_win),
    .slot_q (s1_slot)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_words <= '0;
      s1_vld   <= 1'b0;
    end else begin
      s1_words <= s0_words;
      s1_vld   <= s0_vld;
    end
  end

  // Stage 2: slot routing and quality lookup.
  bsel_route #(.N_CAND(N_CAND), .RANK_W(RANK_W), .PAY_W(PAY_W), .N_OUT(N_OUT), .Q_W(Q_W)) u_route (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .vld_i   (s1_vld),
    .words_i (s1_words),
    .win_i   (s1_win),
    .slot_i  (s1_slot),
    .xvld_q  (out_xvld),
    .vld_q   (out_vld),
    .q_q     (out_q),
    .pay_q   (out_pay),
    .src_q   (out_src),
    .win_q   (win_o)
  );

  // Capture buffers.
  logic [N_OUT*W-1:0] out_lanes;
  for (genvar gk = 0; gk < N_OUT; gk++) begin : g_lane
    assign out_lanes[gk*W +: W] = {out_pay[gk*PAY_W +: PAY_W], RANK_W'(out_q[gk*Q_W +: Q_W])};
  end

  logic [W-1:0] rd_in, rd_out;
  logic         full_in, full_out;

  bsel_capbuf #(.DEPTH(CAP_DEPTH), .N_LANE(N_CAND), .LANE_W(W), .SEL_W(LSEL_W)) u_cap_in (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_i    (s0_vld),
    .data_i  (s0_words),
    .clr_i   (tcap_clr),
    .adv_i   (tcap_adv),
    .lane_i  (tcap_lane),
    .rdata_o (rd_in),
    .full_o  (full_in)
  );

  bsel_capbuf #(.DEPTH(CAP_DEPTH), .N_LANE(N_OUT), .LANE_W(W), .SEL_W(LSEL_W)) u_cap_out (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_i    (out_xvld),
    .data_i  (out_lanes),
    .clr_i   (tcap_clr),
    .adv_i   (tcap_adv),
    .lane_i  (tcap_lane),
    .rdata_o (rd_out),
    .full_o  (full_out)
  );

  cap_sel_e sel;
  assign sel        = cap_sel_e'(tcap_sel);
  assign tcap_rdata = (sel == CAP_OUT) ? rd_out : rd_in;
  assign tcap_full  = {full_out, full_in};

endmodule

// File: tb/trk_rank_sel_bench.sv
module trk_rank_sel_bench;

  localparam int NC = 36, RW = 7, PW = 4, W = 11, NO = 4, QW = 3, IW = 6;

  logic clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0;
  logic [NC*W-1:0] cand = '0;
  logic tcap_clr = 1'b0, tcap_adv = 1'b0, tcap_sel = 1'b0;
  logic [5:0] tcap_lane = '0;
  logic out_xvld;
  logic [NO-1:0] out_vld;
  logic [NO*QW-1:0] out_q;
  logic [NO*PW-1:0] out_pay;
  logic [NO*IW-1:0] out_src;
  logic [NC-1:0] win_o;
  logic [W-1:0] tcap_rdata;
  logic [1:0] tcap_full;

  trk_rank_sel u_trk_rank_sel (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cand_i(cand),
    .out_xvld(out_xvld), .out_vld(out_vld), .out_q(out_q), .out_pay(out_pay),
    .out_src(out_src), .win_o(win_o), .tcap_clr(tcap_clr), .tcap_adv(tcap_adv),
    .tcap_sel(tcap_sel), .tcap_lane(tcap_lane), .tcap_rdata(tcap_rdata), .tcap_full(tcap_full)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    int               due;
    logic             xvld;
    logic [NO-1:0]    vld;
    logic [NO*QW-1:0] q;
    logic [NO*PW-1:0] pay;
    logic [NO*IW-1:0] src;
    logic [NC-1:0]    win;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result straight from the requirements: repeated pick of the best remaining.
  function automatic exp_t model(logic v, logic [NC*W-1:0] w);
    exp_t e;
    logic [NC-1:0] taken;
    e = '0;
    taken = '0;
    e.xvld = v;
    if (v) begin
      for (int k = 0; k < NO; k++) begin
        int best, br;
        best = -1;
        br = 0;
        for (int i = 0; i < NC; i++) begin
          int r;
          r = int'(w[i*W +: RW]);
          if (!taken[i] && r != 0 && r > br) begin
            best = i;
            br = r;
          end
        end
        if (best >= 0) begin
          taken[best] = 1'b1;
          e.vld[k] = 1'b1;
          e.q[k*QW +: QW] = QW'((br * 7 + 126) / 127);
          e.pay[k*PW +: PW] = w[best*W + RW +: PW];
          e.src[k*IW +: IW] = IW'(best);
        end
      end
    end
    e.win = taken;
    return e;
  endfunction

  function automatic logic [NC*W-1:0] pat(int e);
    logic [NC*W-1:0] w;
    for (int i = 0; i < NC; i++)
      w[i*W +: W] = {PW'((e + i) % 16), RW'(((e * 7 + i * 13) % 127) + 1)};
    return w;
  endfunction

  function automatic logic [W-1:0] out_lane(logic [NC*W-1:0] w, int k);
    exp_t m;
    m = model(1'b1, w);
    return {m.pay[k*PW +: PW], RW'(m.q[k*QW +: QW])};
  endfunction

  task automatic drive(logic v, logic [NC*W-1:0] w);
    exp_t e;
    @(negedge clk);
    in_vld = v;
    cand = w;
    e = model(v, w);
    e.due = cyc + 3;
    sb.push_back(e);
  endtask

  task automatic pulse_clr();
    @(negedge clk) tcap_clr = 1'b1;
    @(negedge clk) tcap_clr = 1'b0;
  endtask

  task automatic pulse_adv();
    @(negedge clk) tcap_adv = 1'b1;
    @(negedge clk) tcap_adv = 1'b0;
  endtask

  task automatic rd_chk(string req, logic sel, int lane, logic [W-1:0] exp);
    @(negedge clk);
    tcap_sel = sel;
    tcap_lane = 6'(lane);
    #1;
    chk(req, tcap_rdata, exp);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk("R6 crossing valid", out_xvld, e.xvld);
      chk("R2 R4 slot valid", out_vld, e.vld);
      chk("R5 quality", out_q, e.q);
      chk("R5 payload", out_pay, e.pay);
      chk("R1 R3 source index", out_src, e.src);
      chk("R7 winner flags", win_o, e.win);
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [NC*W-1:0] w;
    repeat (3) @(negedge clk);
    // Reset state (R6, R8)
    chk("R6 reset xvld", out_xvld, 0);
    chk("R7 reset winners", win_o, 0);
    chk("R8 reset full", tcap_full, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: single candidate
    w = '0; w[20*W +: W] = {4'hA, 7'd5};
    drive(1'b1, w);
    // R4: all empty but valid
    drive(1'b1, '0);
    // R3: all ties
    w = '0;
    for (int i = 0; i < NC; i++) w[i*W +: W] = {PW'(i), 7'd50};
    drive(1'b1, w);
    // R3: mixed ties
    w = '0;
    w[35*W +: W] = {4'h3, 7'd30}; w[10*W +: W] = {4'h5, 7'd30}; w[7*W +: W] = {4'h9, 7'd90};
    drive(1'b1, w);
    // R5: lookup boundaries
    w = '0;
    w[0*W +: W] = {4'h1, 7'd1}; w[35*W +: W] = {4'hF, 7'd127};
    w[17*W +: W] = {4'h2, 7'd18}; w[19*W +: W] = {4'h4, 7'd19};
    drive(1'b1, w);
    // R6: invalid crossing carrying ranks
    drive(1'b0, pat(3));
    drive(1'b1, pat(4));
    // R2 R3: random narrow-band ranks
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < NC; i++)
        w[i*W +: W] = {PW'($urandom_range(0, 15)),
                       ($urandom_range(0, 3) == 0) ? 7'd0 : RW'($urandom_range(100, 110))};
      drive(1'b1, w);
    end
    repeat (5) drive(1'b0, '0);

    // R8 R9: capture with freeze
    pulse_clr();
    drive(1'b0, pat(1));
    drive(1'b1, pat(5));
    drive(1'b0, '0);
    repeat (4) drive(1'b0, '0);
    rd_chk("R8 invalid crossing not captured", 1'b0, 0, pat(5)[0 +: W]);

    pulse_clr();
    @(negedge clk) chk("R9 clear drops full", tcap_full, 0);
    for (int e = 0; e < 70; e++) drive(1'b1, pat(e));
    repeat (6) drive(1'b0, '0);
    @(negedge clk) chk("R8 both buffers full", tcap_full, 2'b11);
    rd_chk("R8 input entry 0", 1'b0, 5, pat(0)[5*W +: W]);
    rd_chk("R8 output entry 0", 1'b1, 0, out_lane(pat(0), 0));
    rd_chk("R9 lane past width", 1'b1, 40, '0);
    for (int a = 0; a < 63; a++) pulse_adv();
    rd_chk("R8 input entry 63 frozen", 1'b0, 35, pat(63)[35*W +: W]);
    rd_chk("R8 output entry 63 frozen", 1'b1, 3, out_lane(pat(63), 3));
    pulse_adv();
    rd_chk("R9 pointer wraps", 1'b0, 0, pat(0)[0 +: W]);
    pulse_clr();
    @(negedge clk) chk("R9 clear after full", tcap_full, 0);

    repeat (4) @(negedge clk);
    chk("R6 scoreboard drained", sb.size(), 0);
    summary();
  end

endmodule